// File: doc/BRIEF.md
# Walsh Spectrum Bit-Stream Analyzer

This block takes one serial bit-stream of fixed length N, one bit per valid beat, such as the values a single circuit input sees across N successive test vectors. Once a start request arrives, it computes the full Walsh-Hadamard spectrum of the stream in place. It then reports each signed coefficient together with a flag that says whether the coefficient carries real content ("essential") or only sits at or below the random-noise floor.

Each loaded bit is first converted to bipolar form. An in-place fast butterfly transform then produces the coefficients in natural (Sylvester) row order. A coefficient counts as essential when its normalized power c²/N² is above the random level 1/N. This is computed without division as c² > N. When the block finishes it raises a one-cycle done pulse. From then on, any coefficient can be read by index through a combinational read port.

Top module: `walsh_spectrum_analyzer`

## Requirements
- R1: A loaded 1 enters the transform as +1 and a loaded 0 enters as -1. The k-th accepted bit after a start (counting from 0) is stream element k. An all-ones stream gives +N at index 0 and an all-zeros stream gives -N at index 0, with every other coefficient 0.
- R2: Coefficient k equals the sum over i of x_i · H[k][i], where H[k][i] = +1 when popcount(k AND i) is even and -1 otherwise. Every coefficient lies in [-N, +N].
- R3: A stream equal to Walsh row k (bit i = 1 exactly where H[k][i] = +1) yields +N at index k and 0 elsewhere. The complemented stream yields -N at index k.
- R4: rd_essential is 1 exactly when rd_coef² > N. A coefficient with c² = N, and a zero coefficient, both read as noise.
- R5: While the transform runs, start and in_valid have no effect. The run length and the results are the same as an undisturbed run.
- R6: done is high for exactly one cycle. It rises after the (log2(N)·N/2)-th rising edge that follows the edge accepting start.
- R7: After reset, done is 0 and every index reads coefficient 0 with rd_essential 0.
- R8: Only the first N bits loaded after a start or reset are kept. Later in_valid beats before the next start are discarded.
- R9: After done, a new stream can be loaded from index 0 and transformed again with a new start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| in_valid | input | 1 | Loads in_bit as the next stream element |
| in_bit | input | 1 | Stream bit |
| start | input | 1 | Begins the transform of the loaded stream |
| done | output | 1 | One-cycle pulse when the spectrum is ready |
| rd_idx | input | log2(N) | Coefficient index to read |
| rd_coef | output | log2(N)+2 | Signed coefficient at rd_idx |
| rd_essential | output | 1 | 1 when the coefficient at rd_idx is essential |

## Verification
Several properties are checked on every cycle: the one-cycle done pulse and its exact run length, the frozen and saturating load counter, the coefficient range, and the consistency of the essential flag at zero and at ±N. The numerical correctness of the whole spectrum can only be shown by the bench's scenarios. These compare every coefficient and flag against a directly computed matrix product, using every Walsh row and its complement, random streams, the c² = N boundary, over-long loads and disturbances during the run.

// File: rtl/walsh_pkg.sv
package walsh_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_BUSY = 2'd1,
    ST_DONE = 2'd2
  } wsa_state_e;
endpackage

// File: rtl/wsa_ctrl.sv
module wsa_ctrl
  import walsh_pkg::*;
#(
  parameter int N    = 128,
  parameter int LOG2 = $clog2(N),
  parameter int PW   = (LOG2 > 1) ? $clog2(LOG2) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              in_valid,
  output logic              ld_we,
  output logic [LOG2:0]     ld_cnt,
  output logic              bf_en,
  output logic [PW-1:0]     pass,
  output logic [LOG2-2:0]   pair,
  output logic              done
);
  localparam logic [PW-1:0]   LAST_PASS = PW'(LOG2 - 1);
  localparam logic [LOG2-2:0] LAST_PAIR = '1;

  wsa_state_e      state_q, state_n;
  logic [LOG2:0]   cnt_n;
  logic [PW-1:0]   pass_n;
  logic [LOG2-2:0] pair_n;
  logic            done_n;
  logic            accepting;

  assign accepting = (state_q != ST_BUSY);
  assign ld_we     = accepting && !start && in_valid && !ld_cnt[LOG2];
  assign bf_en     = (state_q == ST_BUSY);

  always_comb begin
    state_n = state_q;
    cnt_n   = ld_cnt;
    pass_n  = pass;
    pair_n  = pair;
    done_n  = 1'b0;
    if (accepting) begin
      if (start) begin
        state_n = ST_BUSY;
        cnt_n   = '0;
        pass_n  = '0;
        pair_n  = '0;
      end else if (ld_we) begin
        cnt_n = ld_cnt + 1'b1;
      end
    end else begin
      if (pair == LAST_PAIR) begin
        pair_n = '0;
        if (pass == LAST_PASS) begin
          state_n = ST_DONE;
          done_n  = 1'b1;
        end else begin
          pass_n = pass + 1'b1;
        end
      end else begin
        pair_n = pair + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      ld_cnt  <= '0;
      pass    <= '0;
      pair    <= '0;
      done    <= 1'b0;
    end else begin
      state_q <= state_n;
      ld_cnt  <= cnt_n;
      pass    <= pass_n;
      pair    <= pair_n;
      done    <= done_n;
    end
  end
endmodule

// File: rtl/wsa_butterfly.sv
module wsa_butterfly #(
  parameter int LOG2 = 7,
  parameter int W    = LOG2 + 2,
  parameter int PW   = (LOG2 > 1) ? $clog2(LOG2) : 1
) (
  input  logic [PW-1:0]        pass,
  input  logic [LOG2-2:0]      pair,
  input  logic signed [W-1:0]  a,
  input  logic signed [W-1:0]  b,
  output logic [LOG2-1:0]      lo_idx,
  output logic [LOG2-1:0]      hi_idx,
  output logic signed [W-1:0]  sum,
  output logic signed [W-1:0]  dif
);
  logic [LOG2-1:0] pext, span, low_mask;

  always_comb begin
    pext     = LOG2'(pair);
    span     = LOG2'(1) << pass;
    low_mask = span - LOG2'(1);
    lo_idx   = ((pext & ~low_mask) << 1) | (pext & low_mask);
    hi_idx   = lo_idx | span;
    sum      = a + b;
    dif      = a - b;
  end
endmodule

// File: rtl/wsa_classify.sv
module wsa_classify #(
  parameter int N = 128,
  parameter int W = $clog2(N) + 2
) (
  input  logic signed [W-1:0] coef,
  output logic                essential
);
  localparam logic [2*W-1:0] THRESH = (2*W)'(N);

  logic [W-1:0]   mag;
  logic [2*W-1:0] sq;

  always_comb begin
    mag       = coef[W-1] ? W'(-coef) : W'(coef);
    sq        = {{W{1'b0}}, mag} * {{W{1'b0}}, mag};
    essential = (sq > THRESH);
  end
endmodule

// File: rtl/walsh_spectrum_analyzer.sv
module walsh_spectrum_analyzer #(
  parameter int N    = 128,
  parameter int LOG2 = $clog2(N),
  parameter int W    = LOG2 + 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  input  logic                in_bit,
  input  logic                start,
  output logic                done,
  input  logic [LOG2-1:0]     rd_idx,
  output logic signed [W-1:0] rd_coef,
  output logic                rd_essential
);
  localparam int PW = (LOG2 > 1) ? $clog2(LOG2) : 1;
  localparam logic signed [W-1:0] POS1 = W'(1);
  localparam logic signed [W-1:0] NEG1 = '1;

  logic rst_meta, rst_sync;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_sync <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_sync <= rst_meta;
    end
  end

  logic            ld_we, bf_en;
  logic [LOG2:0]   ld_cnt;
  logic [PW-1:0]   pass;
  logic [LOG2-2:0] pair;

  wsa_ctrl #(.N(N), .LOG2(LOG2), .PW(PW)) u_ctrl (
    .clk(clk), .rst_n(rst_sync), .start(start), .in_valid(in_valid),
    .ld_we(ld_we), .ld_cnt(ld_cnt), .bf_en(bf_en),
    .pass(pass), .pair(pair), .done(done)
  );

  logic signed [W-1:0] mem_q [N];
  logic signed [W-1:0] mem_n [N];
  logic [LOG2-1:0]     lo_idx, hi_idx;
  logic signed [W-1:0] bf_sum, bf_dif;

  wsa_butterfly #(.LOG2(LOG2), .W(W), .PW(PW)) u_bfly (
    .pass(pass), .pair(pair),
    .a(mem_q[lo_idx]), .b(mem_q[hi_idx]),
    .lo_idx(lo_idx), .hi_idx(hi_idx),
    .sum(bf_sum), .dif(bf_dif)
  );

  always_comb begin
    for (int i = 0; i < N; i++) mem_n[i] = mem_q[i];
    if (ld_we) begin
      mem_n[ld_cnt[LOG2-1:0]] = in_bit ? POS1 : NEG1;
    end else if (bf_en) begin
      mem_n[lo_idx] = bf_sum;
      mem_n[hi_idx] = bf_dif;
    end
  end

  always_ff @(posedge clk or negedge rst_sync) begin
    if (!rst_sync) begin
      for (int i = 0; i < N; i++) mem_q[i] <= '0;
    end else if (ld_we || bf_en) begin
      for (int i = 0; i < N; i++) mem_q[i] <= mem_n[i];
    end
  end

  assign rd_coef = mem_q[rd_idx];

  wsa_classify #(.N(N), .W(W)) u_cls (
    .coef(rd_coef), .essential(rd_essential)
  );
endmodule

// File: rtl/wsa_checker.sv
module wsa_checker #(
  parameter int N    = 128,
  parameter int LOG2 = $clog2(N),
  parameter int W    = LOG2 + 2
) (
  input logic                clk,
  input logic                rst_n,
  input logic                busy,
  input logic                done,
  input logic [LOG2:0]       ld_cnt,
  input logic signed [W-1:0] rd_coef,
  input logic                rd_essential
);
  localparam int RUN = LOG2 * N / 2;
  localparam logic signed [W-1:0] PN = W'(N);
  localparam logic signed [W-1:0] MN = W'(-N);

  int unsigned run_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_len <= 0;
    else if (busy) run_len <= run_len + 1;
    else run_len <= 0;
  end

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R6
  AST_DONE_RUN_LEN: assert property (@(posedge clk) disable iff (!rst_n) done |-> run_len == RUN); // R6
  AST_LOAD_FROZEN: assert property (@(posedge clk) disable iff (!rst_n) busy |-> ld_cnt == '0); // R5
  AST_LOAD_SATURATE: assert property (@(posedge clk) disable iff (!rst_n) ld_cnt <= (LOG2+1)'(N)); // R8
  AST_COEF_RANGE: assert property (@(posedge clk) disable iff (!rst_n) !busy |-> (rd_coef <= PN && rd_coef >= MN)); // R2
  AST_ZERO_IS_NOISE: assert property (@(posedge clk) disable iff (!rst_n) rd_coef == '0 |-> !rd_essential); // R4
  AST_FULL_IS_ESSENTIAL: assert property (@(posedge clk) disable iff (!rst_n) (rd_coef == PN || rd_coef == MN) |-> rd_essential); // R3
endmodule

bind walsh_spectrum_analyzer wsa_checker #(.N(N), .LOG2(LOG2), .W(W)) u_wsa_chk (
  .clk(clk), .rst_n(rst_sync), .busy(bf_en), .done(done),
  .ld_cnt(ld_cnt), .rd_coef(rd_coef), .rd_essential(rd_essential)
);

// File: tb/walsh_spectrum_analyzer_bench.sv
module walsh_spectrum_analyzer_bench;
  localparam int N    = 16;
  localparam int LOG2 = $clog2(N);
  localparam int W    = LOG2 + 2;
  localparam int RUN  = LOG2 * N / 2;

  logic                clk = 1'b0;
  logic                rst_n, in_valid, in_bit, start;
  logic                done;
  logic [LOG2-1:0]     rd_idx;
  logic signed [W-1:0] rd_coef;
  logic                rd_essential;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  walsh_spectrum_analyzer #(.N(N)) u_walsh_spectrum_analyzer (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_bit(in_bit),
    .start(start), .done(done), .rd_idx(rd_idx),
    .rd_coef(rd_coef), .rd_essential(rd_essential)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int expect_coef(input logic [N-1:0] s, input int k);
    int acc = 0;
    for (int i = 0; i < N; i++) begin
      int x = s[i] ? 1 : -1;
      int h = ($countones(k & i) % 2 == 0) ? 1 : -1;
      acc += x * h;
    end
    return acc;
  endfunction

  function automatic logic [N-1:0] walsh_row(input int k);
    logic [N-1:0] r;
    for (int i = 0; i < N; i++) r[i] = ($countones(k & i) % 2 == 0);
    return r;
  endfunction

  task automatic load_stream(input logic [N-1:0] s);
    for (int i = 0; i < N; i++) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_bit   = s[i];
    end
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic run(input bit disturb, input string req);
    int cyc = 0;
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (cyc < 4 * RUN) begin
      @(negedge clk);
      cyc++;
      if (disturb && cyc == 3) begin
        start = 1'b1; in_valid = 1'b1; in_bit = 1'b1;
      end
      if (disturb && cyc == 6) begin
        start = 1'b0; in_valid = 1'b0;
      end
      if (done) break;
    end
    start = 1'b0; in_valid = 1'b0;
    chk(cyc == RUN, {req, " done latency"}, cyc, RUN);
    @(negedge clk);
    chk(done == 1'b0, "R6 done width", int'(done), 0);
  endtask

  task automatic check_spectrum(input logic [N-1:0] s, input string req);
    for (int k = 0; k < N; k++) begin
      int e = expect_coef(s, k);
      bit ess = (e * e) > N;
      rd_idx = LOG2'(k);
      #1;
      chk(int'(rd_coef) == e, {req, " R2 coef"}, int'(rd_coef), e);
      chk(rd_essential == ess, {req, " R4 essential"}, int'(rd_essential), int'(ess));
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [N-1:0] s;
    rst_n = 1'b0; in_valid = 1'b0; in_bit = 1'b0; start = 1'b0; rd_idx = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    chk(done == 1'b0, "R7 done after reset", int'(done), 0);
    for (int k = 0; k < N; k++) begin
      rd_idx = LOG2'(k);
      #1;
      chk(rd_coef == '0 && !rd_essential, "R7 reset coefficient", int'(rd_coef), 0);
    end

    // R1: all-ones and all-zeros streams
    load_stream('1); run(1'b0, "R1");
    check_spectrum('1, "R1 ones");
    rd_idx = '0; #1;
    chk(int'(rd_coef) == N, "R1 ones dc", int'(rd_coef), N);
    load_stream('0); run(1'b0, "R1");
    rd_idx = '0; #1;
    chk(int'(rd_coef) == -N, "R1 zeros dc", int'(rd_coef), -N);

    // R3: every Walsh row and its complement; R9 reload after each done
    for (int k = 0; k < N; k++) begin
      s = walsh_row(k);
      load_stream(s); run(1'b0, "R9");
      check_spectrum(s, "R3 row");
      rd_idx = LOG2'(k); #1;
      chk(int'(rd_coef) == N && rd_essential, "R3 row peak", int'(rd_coef), N);
      load_stream(~s); run(1'b0, "R9");
      rd_idx = LOG2'(k); #1;
      chk(int'(rd_coef) == -N && rd_essential, "R3 complement peak", int'(rd_coef), -N);
    end

    // R4: c*c == N is noise (ten ones then six zeros gives c0 = 4)
    s = N'(16'h03FF);
    load_stream(s); run(1'b0, "R4");
    rd_idx = '0; #1;
    chk(int'(rd_coef) == 4 && !rd_essential, "R4 boundary noise", int'(rd_essential), 0);
    check_spectrum(s, "R4 boundary");

    // R8: extra bits after N are discarded
    s = N'(16'h5A0F);
    load_stream(s);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk); in_valid = 1'b1; in_bit = ~s[i];
    end
    @(negedge clk); in_valid = 1'b0;
    run(1'b0, "R8");
    check_spectrum(s, "R8 overlong");

    // R5: start and load during the run change nothing
    s = N'(16'hC3A5);
    load_stream(s); run(1'b1, "R5");
    check_spectrum(s, "R5 disturbed");

    // R2: random streams
    for (int t = 0; t < 120; t++) begin
      s = N'($urandom);
      load_stream(s); run(1'b0, "R2");
      check_spectrum(s, "R2 random");
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule